// File: doc/BRIEF.md
# Core Halt Power-State Controller

This block tracks the power state of a single processor core around a halt instruction. It decides when the core clock runs and when the core asks for a reduced supply voltage. A one-cycle halt pulse from the execution pipeline takes a running core into one of two idle states. The plain idle state only stops the core clock. The deeper idle state stops the clock and also requests low voltage. An enable input chooses between them, and the block reads that input only on the cycle the halt is accepted.

An idle core wakes up on an interrupt. An external bus snoop can also bring the core clock back for a while. When the snoop-done signal arrives, the block returns to the idle state it came from, with no software involved. A snoop taken from the deeper idle state keeps the low-voltage request asserted for its whole length. An interrupt that arrives during a snoop is held until the snoop finishes, and the core then goes to running instead of back to idle. The clock enable for the bus-interface and interrupt-controller domains is on in every state. All outputs come straight from flip-flops.

Top module: `halt_pstate_ctrl`

## Requirements
- R1: After a synchronous reset the state code is 0 (running), the core clock enable is 1 and the low-voltage request is 0.
- R2: A halt pulse while running, with the enhanced enable at 0, gives state code 1 on the next cycle, with core clock enable 0 and low-voltage request 0.
- R3: A halt pulse while running, with the enhanced enable at 1, gives state code 2 on the next cycle, with core clock enable 0 and low-voltage request 1.
- R4: The always-on clock enable is 1 in every state.
- R5: An interrupt in state 1 or 2 gives state code 0 on the next cycle, with core clock enable 1 and low-voltage request 0.
- R6: A snoop request in state 1 gives state code 3 with core clock enable 1 and low-voltage request 0. Snoop done with no interrupt seen returns to state 1.
- R7: A snoop request in state 2 gives state code 4 with core clock enable 1 and low-voltage request held at 1. Snoop done with no interrupt seen returns to state 2.
- R8: An interrupt during state 3 or 4 leaves the state unchanged until snoop done. Snoop done then gives state code 0.
- R9: A halt pulse in any state other than running has no effect on the state.
- R10: Changing the enhanced enable while idle or snooping has no effect on the state or on the low-voltage request.
- R11: In state 1 or 2, an interrupt together with a snoop request gives state code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| halt_pulse_i | input | 1 | One-cycle pulse when a halt instruction executes |
| irq_i | input | 1 | Interrupt request |
| snoop_req_i | input | 1 | External bus snoop request |
| snoop_done_i | input | 1 | Snoop handling finished |
| enh_halt_en_i | input | 1 | Select the deeper (low-voltage) idle state on halt |
| core_clk_en_o | output | 1 | Core clock enable |
| aon_clk_en_o | output | 1 | Clock enable for bus-interface and interrupt-controller domains |
| low_volt_req_o | output | 1 | Reduced-voltage request |
| state_code_o | output | 3 | State code: 0 run, 1 idle, 2 deep idle, 3 snoop, 4 low-voltage snoop |

## Verification
The bench builds the block with IRQ_LATCH_EN at its default of 1. In that variant a single-cycle interrupt pulse in the middle of a snoop is enough to send the core to running once the snoop finishes, so the bench can reach R8 with pulses as well as with held levels. The random phase mixes halt, interrupt, snoop and enable toggles. This reaches every transition of the five states, including interrupt and snoop arriving together and snoop done arriving on the same cycle as an interrupt.

// File: rtl/halt_pstate_pkg.sv
`timescale 1ns/1ps
package halt_pstate_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    PS_RUN     = 3'd0,
    PS_IDLE    = 3'd1,
    PS_IDLE_LV = 3'd2,
    PS_SNP     = 3'd3,
    PS_SNP_LV  = 3'd4
  } pstate_e;

  function automatic logic is_idle(pstate_e s);
    return (s == PS_IDLE) || (s == PS_IDLE_LV);
  endfunction

  function automatic logic is_snoop(pstate_e s);
    return (s == PS_SNP) || (s == PS_SNP_LV);
  endfunction
endpackage

// File: rtl/halt_pstate_next.sv
`timescale 1ns/1ps
module halt_pstate_next
  import halt_pstate_pkg::*;
(
  input  pstate_e state_q,
  input  logic    halt_i,
  input  logic    irq_i,
  input  logic    snoop_req_i,
  input  logic    snoop_done_i,
  input  logic    enh_en_i,
  input  logic    irq_held_i,
  output pstate_e state_d
);
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN: begin
        // the enhanced enable is looked at only here, on halt entry
        if (halt_i) state_d = enh_en_i ? PS_IDLE_LV : PS_IDLE;
      end
      PS_IDLE: begin
        if (irq_i)            state_d = PS_RUN;
        else if (snoop_req_i) state_d = PS_SNP;
      end
      PS_IDLE_LV: begin
        if (irq_i)            state_d = PS_RUN;
        else if (snoop_req_i) state_d = PS_SNP_LV;
      end
      PS_SNP: begin
        if (snoop_done_i) state_d = (irq_held_i || irq_i) ? PS_RUN : PS_IDLE;
      end
      PS_SNP_LV: begin
        if (snoop_done_i) state_d = (irq_held_i || irq_i) ? PS_RUN : PS_IDLE_LV;
      end
      default: state_d = PS_RUN;
    endcase
  end
endmodule

// File: rtl/halt_pstate_irq_hold.sv
`timescale 1ns/1ps
module halt_pstate_irq_hold
  import halt_pstate_pkg::*;
#(
  parameter bit LATCH_EN = 1'b1
) (
  input  logic    clk_i,
  input  logic    rst_i,
  input  pstate_e state_q,
  input  pstate_e state_d,
  input  logic    irq_i,
  output logic    irq_held_o
);
  generate
    if (LATCH_EN) begin : g_latch
      logic held_q;
      always_ff @(posedge clk_i) begin
        if (rst_i)                  held_q <= 1'b0;
        else if (!is_snoop(state_d)) held_q <= 1'b0;
        else if (is_snoop(state_q) && irq_i) held_q <= 1'b1;
      end
      assign irq_held_o = held_q;
    end else begin : g_level
      // interrupt must stay asserted until snoop done in this variant
      assign irq_held_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/halt_pstate_outreg.sv
`timescale 1ns/1ps
module halt_pstate_outreg
  import halt_pstate_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_i,
  input  pstate_e state_d,
  output pstate_e state_q,
  output logic    core_clk_en_o,
  output logic    aon_clk_en_o,
  output logic    low_volt_req_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q        <= PS_RUN;
      core_clk_en_o  <= 1'b1;
      aon_clk_en_o   <= 1'b1;
      low_volt_req_o <= 1'b0;
    end else begin
      state_q        <= state_d;
      core_clk_en_o  <= !is_idle(state_d);
      aon_clk_en_o   <= 1'b1;
      low_volt_req_o <= (state_d == PS_IDLE_LV) || (state_d == PS_SNP_LV);
    end
  end

  // R7
  snoop_lv_volt_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == PS_SNP_LV) |-> low_volt_req_o);

  // R2
  idle_clk_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    is_idle(state_q) |-> !core_clk_en_o);
endmodule

// File: rtl/halt_pstate_ctrl.sv
`timescale 1ns/1ps
module halt_pstate_ctrl
  import halt_pstate_pkg::*;
#(
  parameter bit IRQ_LATCH_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              halt_pulse_i,
  input  logic              irq_i,
  input  logic              snoop_req_i,
  input  logic              snoop_done_i,
  input  logic              enh_halt_en_i,
  output logic              core_clk_en_o,
  output logic              aon_clk_en_o,
  output logic              low_volt_req_o,
  output logic [CODE_W-1:0] state_code_o
);
  pstate_e state_q;
  pstate_e state_d;
  logic    irq_held;

  halt_pstate_next u_next (
    .state_q      (state_q),
    .halt_i       (halt_pulse_i),
    .irq_i        (irq_i),
    .snoop_req_i  (snoop_req_i),
    .snoop_done_i (snoop_done_i),
    .enh_en_i     (enh_halt_en_i),
    .irq_held_i   (irq_held),
    .state_d      (state_d)
  );

  halt_pstate_irq_hold #(.LATCH_EN(IRQ_LATCH_EN)) u_hold (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .state_q    (state_q),
    .state_d    (state_d),
    .irq_i      (irq_i),
    .irq_held_o (irq_held)
  );

  halt_pstate_outreg u_out (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .state_d        (state_d),
    .state_q        (state_q),
    .core_clk_en_o  (core_clk_en_o),
    .aon_clk_en_o   (aon_clk_en_o),
    .low_volt_req_o (low_volt_req_o)
  );

  assign state_code_o = state_q;

  // R2
  halt_to_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_code_o == 3'd0 && halt_pulse_i && !enh_halt_en_i) |=> (state_code_o == 3'd1));

  // R3
  halt_to_deep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_code_o == 3'd0 && halt_pulse_i && enh_halt_en_i) |=> (state_code_o == 3'd2 && low_volt_req_o));

  // R5
  wake_on_irq_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((state_code_o == 3'd1 || state_code_o == 3'd2) && irq_i) |=> (state_code_o == 3'd0 && core_clk_en_o));

  // R8
  snoop_wait_done_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((state_code_o == 3'd3 || state_code_o == 3'd4) && !snoop_done_i) |=> $stable(state_code_o));

  // R6
  snoop_return_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_code_o == 3'd3 && snoop_done_i && !irq_i && !irq_held) |=> (state_code_o == 3'd1));

  // R9
  halt_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((state_code_o == 3'd1 || state_code_o == 3'd2) && !irq_i && !snoop_req_i) |=> $stable(state_code_o));
endmodule

// File: tb/halt_pstate_ctrl_tb.sv
`timescale 1ns/1ps
module halt_pstate_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst, halt, irq, sreq, sdone, en;
  logic core_en, aon_en, lv;
  logic [2:0] code;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  logic [2:0] exp_code = 3'd0;
  logic       exp_held = 1'b0;
  string      cur_tag  = "R1";

  always #4 clk = ~clk;

  halt_pstate_ctrl #(.IRQ_LATCH_EN(1'b1)) dut_i (
    .clk_i(clk), .rst_i(rst), .halt_pulse_i(halt), .irq_i(irq),
    .snoop_req_i(sreq), .snoop_done_i(sdone), .enh_halt_en_i(en),
    .core_clk_en_o(core_en), .aon_clk_en_o(aon_en),
    .low_volt_req_o(lv), .state_code_o(code));

  function automatic logic [2:0] model_next(logic [2:0] s, logic h, logic i,
      logic r, logic d, logic e, logic p);
    case (s)
      3'd0: return h ? (e ? 3'd2 : 3'd1) : 3'd0;
      3'd1: return i ? 3'd0 : (r ? 3'd3 : 3'd1);
      3'd2: return i ? 3'd0 : (r ? 3'd4 : 3'd2);
      3'd3: return d ? ((p || i) ? 3'd0 : 3'd1) : 3'd3;
      3'd4: return d ? ((p || i) ? 3'd0 : 3'd2) : 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] s);
    case (s)
      3'd0: return "R5";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk(cur_tag, "state_code", code, exp_code);
    chk(cur_tag, "core_clk_en", core_en, (exp_code == 3'd1 || exp_code == 3'd2) ? 0 : 1);
    chk(cur_tag, "low_volt_req", lv, (exp_code == 3'd2 || exp_code == 3'd4) ? 1 : 0);
    chk("R4", "aon_clk_en", aon_en, 1);
  endtask

  // check outputs from the previous cycle, then apply new inputs and advance the model
  task automatic step(logic h, logic i, logic r, logic d, logic e, string tag);
    logic [2:0] nx;
    @(negedge clk);
    check_outputs();
    halt = h; irq = i; sreq = r; sdone = d; en = e;
    nx = model_next(exp_code, h, i, r, d, e, exp_held);
    exp_held = ((nx == 3'd3 || nx == 3'd4) && (exp_code == 3'd3 || exp_code == 3'd4))
               ? (exp_held | i) : 1'b0;
    exp_code = nx;
    cur_tag = (tag == "") ? tag_of(nx) : tag;
  endtask

  initial begin
    rst = 1'b1; halt = 0; irq = 0; sreq = 0; sdone = 0; en = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_tag = "R1";
    step(0,0,0,0,0,"R1");
    step(1,0,0,0,0,"R2");
    step(1,0,0,0,1,"R9");
    step(0,0,0,0,1,"R10");
    step(0,0,1,0,0,"R6");
    step(0,0,0,0,1,"R10");
    step(0,0,0,1,0,"R6");
    step(0,1,0,0,0,"R5");
    step(1,0,0,0,1,"R3");
    step(0,0,0,0,0,"R10");
    step(0,0,1,0,0,"R7");
    step(1,1,0,0,0,"R8");
    step(0,0,0,0,1,"R8");
    step(0,0,0,1,0,"R8");
    step(1,0,0,0,1,"R3");
    step(0,0,1,0,0,"R7");
    step(0,0,0,1,0,"R7");
    step(0,1,1,0,0,"R11");
    step(1,0,0,0,0,"R2");
    step(0,0,1,0,0,"R6");
    step(0,1,0,1,0,"R8");
    begin
      process p;
      p = process::self();
      p.srandom(32'd1234);
    end
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 4) == 0, ($urandom % 8) == 0, ($urandom % 4) == 0,
           ($urandom % 3) == 0, $urandom % 2, "");
    end
    step(0,0,0,0,0,"");
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done_flag) begin
      done_flag = 1;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule